// File: doc/BRIEF.md
# Sequential Modular Power Unit with Probable-Prime Indication

This unit raises a base to an exponent modulo an odd or even modulus of up to 31 bits, working square-and-multiply style from the exponent's top set bit towards bit zero. Every modular product, whether a square or a multiply by the base, passes through one shared shift-and-add multiplier. That multiplier walks the multiplier operand one bit per cycle and keeps its partial sums reduced below the modulus.

A caller places the operands on the inputs and pulses `start` while the unit is idle. After a run of cycles that depends on the data, `done` pulses and `result` carries the power. Alongside it, `probable_prime` tells whether the power came out as 1 or as modulus minus 1. If the exponent is set to (modulus-1)/2 for an odd modulus, this flag gives an Euler-criterion probable-prime verdict for that modulus.

Top module: `modexp_unit`

## Requirements
- R1: An exponent of zero produces `result` = 1, with `done` on the second rising edge after the edge that accepts `start`, and no modular product is formed.
- R2: For a modulus of at least 2 and operands below 2^31, `result` equals base^exp mod modulus when `done` pulses.
- R3: A base equal to or larger than the modulus is first reduced modulo the modulus, so the result equals (base mod modulus)^exp mod modulus.
- R4: `probable_prime` is 1 exactly when `result` equals 1 or equals modulus-1.
- R5: `done` is high for one cycle. While the unit stays idle and no new `start` arrives, `result` and `probable_prime` hold their values.
- R6: A `start` pulse that arrives while `busy` is high has no effect, and the operation already under way completes with its own operands.
- R7: `busy` rises on the edge that accepts `start` and falls on the edge where `done` rises. In reset, `busy`, `done` and `result` are 0.
- R8: With base 1234567 and exp=(p-1)/2, the primes 1000000007, 1000000009, 1000000021 and 1000000033 raise `probable_prime`, and the composite 1000000001 does not.
- R9: An exponent of 1 with a base below the modulus returns the base on the second edge after acceptance, without any squaring.
- R10: Whenever `done` pulses, `result` is below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation while idle |
| base_i | input | 31 | Base operand |
| exp_i | input | 31 | Exponent operand |
| modulus_i | input | 31 | Modulus, at least 2 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 31 | base^exp mod modulus |
| probable_prime | output | 1 | Result is 1 or modulus-1 |

## Verification
The checker assumes that every accepted modulus is at least 2. Its range check on `result` and its exact-one result for a zero exponent depend on that assumption, and the inner reduction steps only stay valid when the modulus exceeds 1. Every vector and directed case in the bench uses a modulus of 2 or more. The bench holds `start` and the operands steady across the accepting edge, so the assertions keyed on acceptance see clean operands. The operands it offers during a busy period are chosen to differ from the running ones, which makes a wrongly captured operand visible.

// File: rtl/modexp_unit.sv
module modexp_unit #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] modulus_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         probable_prime
);
  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_SQR, S_MUL, S_RED} st_t;

  st_t          st;
  logic [W-1:0] acc, base_q, exp_q, p_q, mask, lead;
  logic [W-1:0] ma, mb, mr;
  logic         mbusy, done_q;
  logic [W:0]   sum, sum_r, dbl, dbl_r;

  wire mdone = mbusy && (mb == '0);

  assign sum   = {1'b0, mr} + {1'b0, ma};
  assign sum_r = (sum >= {1'b0, p_q}) ? sum - {1'b0, p_q} : sum;
  assign dbl   = {ma, 1'b0};
  assign dbl_r = (dbl >= {1'b0, p_q}) ? dbl - {1'b0, p_q} : dbl;

  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (exp_i[i]) lead = W'(1) << i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      acc    <= '0;
      base_q <= '0;
      exp_q  <= '0;
      p_q    <= '0;
      mask   <= '0;
      ma     <= '0;
      mb     <= '0;
      mr     <= '0;
      mbusy  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mbusy && !mdone) begin
        if (mb[0]) mr <= sum_r[W-1:0];
        ma <= dbl_r[W-1:0];
        mb <= mb >> 1;
      end
      if (mdone) mbusy <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_i;
          exp_q  <= exp_i;
          p_q    <= modulus_i;
          mask   <= lead >> 1;
          if (exp_i == '0) begin
            acc  <= W'(1);
            mask <= '0;
            st   <= S_SCAN;
          end else if (base_i >= modulus_i) begin
            ma <= W'(1); mb <= base_i; mr <= '0; mbusy <= 1'b1;
            st <= S_RED;
          end else begin
            acc <= base_i;
            st  <= S_SCAN;
          end
        end
        S_SCAN: if (mask == '0) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else begin
          ma <= acc; mb <= acc; mr <= '0; mbusy <= 1'b1;
          st <= S_SQR;
        end
        S_SQR: if (mdone) begin
          acc <= mr;
          if ((exp_q & mask) != '0) begin
            ma <= mr; mb <= base_q; mr <= '0; mbusy <= 1'b1;
            st <= S_MUL;
          end else begin
            mask <= mask >> 1;
            st   <= S_SCAN;
          end
        end
        S_MUL: if (mdone) begin
          acc  <= mr;
          mask <= mask >> 1;
          st   <= S_SCAN;
        end
        S_RED: if (mdone) begin
          acc    <= mr;
          base_q <= mr;
          st     <= S_SCAN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy           = (st != S_IDLE);
  assign done           = done_q;
  assign result         = acc;
  assign probable_prime = (acc == W'(1)) || (acc == p_q - W'(1));
endmodule

module modexp_unit_chk #(
  parameter int W = 31
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] exp_i,
  input logic [W-1:0] result,
  input logic         probable_prime,
  input logic [W-1:0] p_q
);
  a_r1_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && exp_i == '0) |=> ##1 (done && result == W'(1)));
  a_r4_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (probable_prime == (result == W'(1) || result == p_q - W'(1))));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(p_q));
  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < p_q));
endmodule

bind modexp_unit modexp_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .exp_i(exp_i), .result(result), .probable_prime(probable_prime), .p_q(p_q)
);

// File: tb/tb_modexp_unit.sv
`timescale 1ns/1ps
module tb_modexp_unit;
  localparam int W = 31;
  localparam int NV = 14;
  localparam logic [W-1:0] VB [NV] = '{31'd3, 31'd2, 31'd5, 31'd7, 31'd20, 31'd0,
    31'h7FFFFFFF, 31'd123456789, 31'd9, 31'd1234567, 31'd1234567, 31'd1234567,
    31'd1234567, 31'd1234567};
  localparam logic [W-1:0] VE [NV] = '{31'd4, 31'd10, 31'd0, 31'd1, 31'd3, 31'd5,
    31'h7FFFFFFF, 31'h7FFFFFFF, 31'd12, 31'd500000003, 31'd500000004,
    31'd500000010, 31'd500000016, 31'd500000000};
  localparam logic [W-1:0] VP [NV] = '{31'd7, 31'd1000, 31'd13, 31'd11, 31'd7, 31'd13,
    31'h7FFFFFFE, 31'h7FFFFFFF, 31'd2, 31'd1000000007, 31'd1000000009,
    31'd1000000021, 31'd1000000033, 31'd1000000001};
  // 2: known prime, 0: known composite, 1: no flag expectation beyond R4
  localparam int VK [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] base_i = '0, exp_i = '0, modulus_i = '0;
  logic busy, done, probable_prime;
  logic [W-1:0] result;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  modexp_unit #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i),
    .exp_i(exp_i), .modulus_i(modulus_i), .busy(busy), .done(done), .result(result),
    .probable_prime(probable_prime));

  function automatic longint ref_pow(longint b, longint e, longint p);
    longint r = 1 % p;
    b = b % p;
    while (e > 0) begin
      if (e[0]) r = (r * b) % p;
      b = (b * b) % p;
      e = e >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [W-1:0] b, e, p, output int lat);
    @(negedge clk);
    base_i = b; exp_i = e; modulus_i = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R7 done seen", done, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    longint er;
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0, "R7 reset state", {busy, done, result}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VB[i], VE[i], VP[i], lat);
      er = ref_pow(VB[i], VE[i], VP[i]);
      check(result == er, VB[i] >= VP[i] ? "R3 reduced base" : "R2 power", result, er);
      check(probable_prime == (er == 1 || er == VP[i] - 1), "R4 flag", probable_prime,
            (er == 1 || er == VP[i] - 1));
      check(result < VP[i], "R10 range", result, VP[i]);
      if (VK[i] == 2) check(probable_prime, "R8 prime flagged", probable_prime, 1);
      if (VK[i] == 0) check(!probable_prime, "R8 composite rejected", probable_prime, 0);
      @(negedge clk);
      check(!done && !busy, "R5 done one cycle", done, 0);
    end

    run_op(31'd77, 31'd0, 31'd101, lat);
    check(lat == 2 && result == 1, "R1 zero exponent", lat, 2);
    run_op(31'd55, 31'd1, 31'd101, lat);
    check(lat == 2 && result == 55, "R9 unit exponent", result, 55);

    run_op(31'd1234567, 31'd500000003, 31'd1000000007, lat);
    repeat (5) @(negedge clk);
    check(result == 1000000006 && probable_prime, "R5 hold while idle", result, 1000000006);

    @(negedge clk);
    base_i = 31'd6; exp_i = 31'd1000; modulus_i = 31'd1009; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R7 busy during run", busy, 1);
    base_i = 31'd2; exp_i = 31'd0; modulus_i = 31'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    er = ref_pow(6, 1000, 1009);
    check(result == er, "R6 start ignored while busy", result, er);
    @(negedge clk);
    check(!busy, "R6 single completion", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule